// File: doc/BRIEF.md
# DRAM Auto-Refresh and Self-Refresh Scheduler

This block sits beside the command arbiter of a DDR SDRAM controller and decides when refresh work must reach the memory. A free-running interval counter, measured in controller clocks, adds one owed refresh each time it expires. While any refresh is owed the block asks the arbiter for a refresh slot. If the banks are not all precharged, it first asks for a precharge-all. The arbiter may defer the grant, so refreshes are postponed. The owed count is capped at eight, and at that cap an urgent flag tells the arbiter to stop deferring. Each granted refresh blocks every other command for the refresh row cycle time.

The block also runs self-refresh. While the self-refresh request input is held, the block asks for the entry command once all banks are idle, and it drops clock enable when that command is granted. No refresh debt accrues while the device refreshes itself. When the request is released, the block asks for the exit command and raises clock enable on the grant. It then applies two separate waits: a short one before any command, and a long one before a read.

Top module: `dram_refresh_sched`

## Requirements
- R1: Outside self-refresh, the owed count rises by one every INTERVAL_CYC clocks. The first increment lands exactly INTERVAL_CYC clock edges after reset is released.
- R2: The owed count never exceeds MAX_OWED (8). Further interval expiries at the cap are dropped. `urgent` is high whenever the count equals MAX_OWED.
- R3: Once high, `urgent` stays high until a refresh is granted, and it falls in the cycle after that grant.
- R4: When work is pending and `allIdle` is low, `pchgReq` is high and `reqValid` is low. When `allIdle` is high, `reqValid` is high and `pchgReq` is low. Auto refresh is shown as `reqKind` = 2'b01.
- R5: A grant (`gnt` high while `reqValid` is high) of an auto refresh lowers the owed count by one. `holdOff` is then high for exactly TRFC_CYC cycles, and no new request is made during that time.
- R6: An interval expiry and a refresh grant on the same clock edge leave the owed count unchanged.
- R7: A held `selfRefReq` takes priority over auto refresh and obeys the same precharge rule as R4. Its entry request is `reqKind` = 2'b10. On that grant, `cke` goes low and the owed count is cleared.
- R8: While in self-refresh with `selfRefReq` still high, no request is made and no refresh is owed. Releasing `selfRefReq` raises a request with `reqKind` = 2'b11.
- R9: On the exit grant, `cke` returns high. `holdOff` is then high for exactly TXSNR_CYC cycles and `readBlock` for exactly TXSRD_CYC cycles. The interval restarts from the exit edge, so the next increment lands INTERVAL_CYC edges later.
- R10: In reset, the block shows no request, no precharge request, `cke` high, no hold-off or read block, owed count 0 and `urgent` low.
- R11: `gnt` has no effect while `reqValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| allIdle | input | 1 | All banks are in the precharged state |
| selfRefReq | input | 1 | Level request to stay in self-refresh |
| gnt | input | 1 | Arbiter accepts the current request this cycle |
| reqValid | output | 1 | A command of kind `reqKind` is requested |
| reqKind | output | 2 | 01 auto refresh, 10 self-refresh entry, 11 self-refresh exit, 00 none |
| pchgReq | output | 1 | Request to precharge all banks |
| urgent | output | 1 | Owed count is at its cap |
| owedCount | output | $clog2(MAX_OWED+1) | Refreshes currently owed |
| cke | output | 1 | Clock enable level for the memory |
| holdOff | output | 1 | No command may be issued |
| readBlock | output | 1 | No read command may be issued |

## Verification
The interval is swept through all eight owed levels and beyond, with the arbiter withholding grants. This separates correct saturation and a held urgent flag from wraparound or a premature release. Grants are given in three ways: one with no request, one inside the interval, and one on the exact edge where an expiry lands. These separate a missing request qualifier, a wrong decrement and a broken same-edge merge. The self-refresh pass toggles bank idleness before entry and idles for two full intervals inside. It then counts the hold-off and read-block cycles after exit, which separates the two exit waits from each other and from the refresh hold-off.

// File: rtl/refsched_pkg.sv
`timescale 1ns/1ps
package refsched_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_REF  = 2'b01,
    KIND_SRE  = 2'b10,
    KIND_SRX  = 2'b11
  } reqKind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRFC,
    ST_SELF,
    ST_XS
  } schedState_e;

  typedef struct packed {
    logic refDone;   // auto refresh granted
    logic srEnter;   // self-refresh entry granted
    logic srHold;    // interval frozen (self-refresh)
    logic loadTrfc;  // start refresh row cycle wait
    logic loadXs;    // start self-refresh exit wait
  } ctrlStrobe_t;

endpackage

// File: rtl/refsched_dp.sv
`timescale 1ns/1ps
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int INTERVAL_CYC = 975,
  parameter int MAX_OWED     = 8,
  parameter int TRFC_CYC     = 10,
  parameter int TXSNR_CYC    = 10,
  parameter int TXSRD_CYC    = 200
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ctrlStrobe_t                       strobe,
  output logic [$clog2(MAX_OWED+1)-1:0]     owedCount,
  output logic                              owedNonZero,
  output logic                              owedFull,
  output logic                              waitZero,
  output logic                              xsCmdOpen
);
  localparam int INT_W  = $clog2(INTERVAL_CYC);
  localparam int OWED_W = $clog2(MAX_OWED + 1);
  localparam int WAIT_MAX = (TRFC_CYC > TXSRD_CYC) ? TRFC_CYC : TXSRD_CYC;
  localparam int WAIT_W = $clog2(WAIT_MAX + 1);
  localparam logic [INT_W-1:0]  INT_RELOAD = INT_W'(INTERVAL_CYC - 1);
  localparam logic [OWED_W-1:0] OWED_MAX   = OWED_W'(MAX_OWED);
  localparam logic [WAIT_W-1:0] TRFC_LOAD  = WAIT_W'(TRFC_CYC - 1);
  localparam logic [WAIT_W-1:0] XS_LOAD    = WAIT_W'(TXSRD_CYC - 1);
  localparam logic [WAIT_W-1:0] XS_OPEN    = WAIT_W'(TXSRD_CYC - TXSNR_CYC);

  logic [INT_W-1:0]  intCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic              tick;

  assign tick = !strobe.srHold && (intCnt == '0);

  // interval counter
  always_ff @(posedge clk) begin
    if (!rstN)                          intCnt <= INT_RELOAD;
    else if (strobe.srHold || tick)     intCnt <= INT_RELOAD;
    else                                intCnt <= intCnt - 1'b1;
  end

  // owed refresh counter
  always_ff @(posedge clk) begin
    if (!rstN)                                        owedCount <= '0;
    else if (strobe.srEnter)                          owedCount <= '0;
    else if (tick && !strobe.refDone && !owedFull)    owedCount <= owedCount + 1'b1;
    else if (strobe.refDone && !tick)                 owedCount <= owedCount - 1'b1;
  end

  // shared wait counter for refresh cycle and self-refresh exit
  always_ff @(posedge clk) begin
    if (!rstN)                  waitCnt <= '0;
    else if (strobe.loadTrfc)   waitCnt <= TRFC_LOAD;
    else if (strobe.loadXs)     waitCnt <= XS_LOAD;
    else if (waitCnt != '0)     waitCnt <= waitCnt - 1'b1;
  end

  assign owedNonZero = (owedCount != '0);
  assign owedFull    = (owedCount == OWED_MAX);
  assign waitZero    = (waitCnt == '0);
  assign xsCmdOpen   = (waitCnt < XS_OPEN);

  p_owed_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    owedCount <= OWED_MAX);
  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    owedFull && !strobe.refDone && !strobe.srEnter |=> owedFull);
  p_grant_no_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refDone |=> owedCount <= $past(owedCount));
  p_entry_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.srEnter |=> owedCount == '0);

endmodule

// File: rtl/refsched_ctrl.sv
`timescale 1ns/1ps
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allIdle,
  input  logic        selfRefReq,
  input  logic        gnt,
  input  logic        owedNonZero,
  input  logic        waitZero,
  input  logic        xsCmdOpen,
  output ctrlStrobe_t strobe,
  output logic        reqValid,
  output logic [1:0]  reqKind,
  output logic        pchgReq,
  output logic        cke,
  output logic        holdOff,
  output logic        readBlock
);
  schedState_e state, stateNext;
  reqKind_e    kind;
  logic        want, take;

  assign want = selfRefReq || owedNonZero;

  always_comb begin
    reqValid = 1'b0;
    pchgReq  = 1'b0;
    kind     = KIND_NONE;
    unique case (state)
      ST_IDLE: begin
        pchgReq  = want && !allIdle;
        reqValid = want && allIdle;
        if (reqValid) kind = selfRefReq ? KIND_SRE : KIND_REF;
      end
      ST_SELF: begin
        reqValid = !selfRefReq;
        if (reqValid) kind = KIND_SRX;
      end
      default: ;
    endcase
  end

  assign take            = reqValid && gnt;
  assign strobe.refDone  = take && (kind == KIND_REF);
  assign strobe.srEnter  = take && (kind == KIND_SRE);
  assign strobe.loadTrfc = strobe.refDone;
  assign strobe.loadXs   = take && (kind == KIND_SRX);
  assign strobe.srHold   = (state == ST_SELF) || strobe.srEnter;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (strobe.srEnter) stateNext = ST_SELF;
               else if (strobe.refDone) stateNext = ST_TRFC;
      ST_TRFC: if (waitZero) stateNext = ST_IDLE;
      ST_SELF: if (strobe.loadXs) stateNext = ST_XS;
      ST_XS:   if (waitZero) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqKind   = kind;
  assign cke       = (state != ST_SELF);
  assign holdOff   = (state == ST_TRFC) || ((state == ST_XS) && !xsCmdOpen);
  assign readBlock = (state == ST_XS);

  p_req_needs_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (reqKind != KIND_SRX) |-> allIdle);
  p_pchg_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(pchgReq && reqValid));
  p_hold_after_ref_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.refDone |=> holdOff && !reqValid);
  p_cke_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.srEnter |=> !cke);
  p_exit_waits_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadXs |=> cke && holdOff && readBlock);

endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched
  import refsched_pkg::*;
#(
  parameter int INTERVAL_CYC = 975,
  parameter int MAX_OWED     = 8,
  parameter int TRFC_CYC     = 10,
  parameter int TXSNR_CYC    = 10,
  parameter int TXSRD_CYC    = 200
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          allIdle,
  input  logic                          selfRefReq,
  input  logic                          gnt,
  output logic                          reqValid,
  output logic [1:0]                    reqKind,
  output logic                          pchgReq,
  output logic                          urgent,
  output logic [$clog2(MAX_OWED+1)-1:0] owedCount,
  output logic                          cke,
  output logic                          holdOff,
  output logic                          readBlock
);
  ctrlStrobe_t strobe;
  logic owedNonZero, waitZero, xsCmdOpen;

  refsched_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .allIdle(allIdle), .selfRefReq(selfRefReq), .gnt(gnt),
    .owedNonZero(owedNonZero), .waitZero(waitZero), .xsCmdOpen(xsCmdOpen),
    .strobe(strobe), .reqValid(reqValid), .reqKind(reqKind), .pchgReq(pchgReq),
    .cke(cke), .holdOff(holdOff), .readBlock(readBlock)
  );

  refsched_dp #(
    .INTERVAL_CYC(INTERVAL_CYC), .MAX_OWED(MAX_OWED), .TRFC_CYC(TRFC_CYC),
    .TXSNR_CYC(TXSNR_CYC), .TXSRD_CYC(TXSRD_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .owedCount(owedCount),
    .owedNonZero(owedNonZero), .owedFull(urgent), .waitZero(waitZero),
    .xsCmdOpen(xsCmdOpen)
  );

endmodule

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
  localparam int CLK_NS = 8;
  localparam int I    = (7800 + CLK_NS - 1) / CLK_NS;
  localparam int TRFC = (75 + CLK_NS - 1) / CLK_NS;
  localparam int TXSNR = (75 + CLK_NS - 1) / CLK_NS;
  localparam int TXSRD = 200;
  localparam int MAXO = 8;

  logic clk = 1'b0, rstN = 1'b0, allIdle = 1'b1, selfRefReq = 1'b0, gnt = 1'b0;
  logic reqValid, pchgReq, urgent, cke, holdOff, readBlock;
  logic [1:0] reqKind;
  logic [3:0] owedCount;
  int cyc = 0, nRun = 0, nFail = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  dram_refresh_sched #(.INTERVAL_CYC(I), .MAX_OWED(MAXO), .TRFC_CYC(TRFC),
    .TXSNR_CYC(TXSNR), .TXSRD_CYC(TXSRD)) u_dut (
    .clk(clk), .rstN(rstN), .allIdle(allIdle), .selfRefReq(selfRefReq), .gnt(gnt),
    .reqValid(reqValid), .reqKind(reqKind), .pchgReq(pchgReq), .urgent(urgent),
    .owedCount(owedCount), .cke(cke), .holdOff(holdOff), .readBlock(readBlock));

  task automatic chk(string req, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cyc %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic waitCyc(int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic pulseGnt();
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
  endtask

  task automatic waitFree();
    while (holdOff) @(negedge clk);
  endtask

  initial begin
    int n, hCnt, rCnt, exitCyc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reqValid", reqValid, 0);
    chk("R10 pchgReq", pchgReq, 0);
    chk("R10 cke", cke, 1);
    chk("R10 holdOff/readBlock", {holdOff, readBlock}, 0);
    chk("R10 owed/urgent", {owedCount, urgent}, 0);
    rstN = 1'b1;
    // R11 grant without request
    pulseGnt();
    chk("R11 owed", owedCount, 0);
    chk("R11 holdOff", holdOff, 0);
    // R1 first tick
    waitCyc(I - 1);
    chk("R1 before tick", owedCount, 0);
    @(negedge clk);
    chk("R1 first tick", owedCount, 1);
    chk("R4 kind refresh", {reqValid, reqKind}, 3'b101);
    allIdle = 1'b0; #1;
    chk("R4 precharge first", {pchgReq, reqValid}, 2'b10);
    allIdle = 1'b1; #1;
    chk("R4 idle request", {pchgReq, reqValid}, 2'b01);
    // R2 sweep of owed levels with grants withheld
    for (int k = 2; k <= 10; k++) begin
      waitCyc(k * I);
      chk("R2 owed level", owedCount, (k < MAXO) ? k : MAXO);
      chk("R2 urgent", urgent, (k >= MAXO) ? 1 : 0);
    end
    // R3/R5 grant releases urgent and holds off
    pulseGnt();
    chk("R5 owed after grant", owedCount, MAXO - 1);
    chk("R3 urgent released", urgent, 0);
    chk("R5 no request in hold", reqValid, 0);
    n = 0;
    while (holdOff) begin n++; @(negedge clk); end
    chk("R5 holdOff length", n, TRFC);
    chk("R5 request resumes", reqValid, 1);
    for (int k = 0; k < MAXO - 2; k++) begin
      pulseGnt();
      waitFree();
    end
    chk("R5 drained", owedCount, 1);
    // R6 grant on the expiry edge
    waitCyc(11 * I - 1);
    pulseGnt();
    chk("R6 same-edge merge", owedCount, 1);
    waitFree();
    // R7 self-refresh entry
    selfRefReq = 1'b1; allIdle = 1'b0; #1;
    chk("R7 precharge before entry", {pchgReq, reqValid}, 2'b10);
    allIdle = 1'b1; #1;
    chk("R7 entry kind", {reqValid, reqKind}, 3'b110);
    pulseGnt();
    chk("R7 cke low", cke, 0);
    chk("R7 owed cleared", owedCount, 0);
    chk("R8 no request held", reqValid, 0);
    waitCyc(cyc + 2 * I);
    chk("R8 no accrual", owedCount, 0);
    chk("R8 still in self-refresh", {cke, reqValid}, 0);
    selfRefReq = 1'b0; #1;
    chk("R8 exit kind", {reqValid, reqKind}, 3'b111);
    pulseGnt();
    exitCyc = cyc;
    chk("R9 cke high", cke, 1);
    hCnt = 0; rCnt = 0;
    for (int t = 0; t < TXSRD + 5; t++) begin
      hCnt += holdOff; rCnt += readBlock;
      @(negedge clk);
    end
    chk("R9 non-read wait", hCnt, TXSNR);
    chk("R9 read wait", rCnt, TXSRD);
    waitCyc(exitCyc + I - 1);
    chk("R9 interval restart before", owedCount, 0);
    @(negedge clk);
    chk("R9 interval restart tick", owedCount, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule